// File: doc/BRIEF.md
# Readout Ethernet frame encapsulator

This block turns one readout packet, collected from a front-end link as a flagged byte stream, into one raw Ethernet frame for the host. The frame carries fixed destination and source addresses, the readout EtherType 0x0811 and an eight-byte application header. The host can then sort readout traffic by link and packet number with no IP stack. The payload follows the header. A short frame is zero-padded to the Ethernet minimum, and a CRC32 frame check sequence ends the frame.

Both streams use valid/ready. An input byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. An output byte is delivered on an edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the output byte and its flags stay frozen. The header carries the payload byte count, so the block stores the whole packet before it starts the frame. Input and output therefore alternate: the block collects one packet, then emits its frame, then collects the next. A buffer of `MAX_PAYLOAD` bytes holds the packet. The packet number and the link index are taken from the byte that carries `in_sof`.

Top module: `rdo_frame_encap`

## Requirements
- R1: Frame bytes 0 to 5 carry `DST_MAC` and bytes 6 to 11 carry `SRC_MAC`, each most significant byte first. Bytes 12 and 13 carry the EtherType `ETHER_TYPE` (default 0x0811), high byte first.
- R2: Bytes 14 to 21 hold four 16-bit fields, each sent high byte first, in this order: the constant `FRAME_TYPE`, then the link index (zero-extended), then the packet number, then the stored payload byte count (padding not counted). The link index and packet number are the values present on the `in_sof` byte.
- R3: The payload bytes start at byte 22 and keep their arrival order.
- R4: When 22 plus the payload count is below 60, zero bytes fill offsets up to 59. Every frame is 4 bytes longer than the larger of (22 plus the payload count) and 60, so no frame is shorter than 64 bytes.
- R5: The last 4 bytes are the IEEE 802.3 CRC32 over all bytes before them. The CRC is reflected, uses polynomial 0x04C11DB7, starts from all ones and is complemented at the end. It is sent least significant byte first.
- R6: `tx_sof` is high only with the first frame byte and `tx_eof` only with the last.
- R7: While `tx_valid` is high and `tx_ready` is low, the next cycle keeps `tx_valid` high with the same `tx_data`, `tx_sof` and `tx_eof`. No byte is lost or repeated.
- R8: `in_ready` is low exactly while a frame is being sent (`tx_valid` high). A frame starts in the cycle after the `in_eof` byte is taken. `in_ready` returns in the cycle after the last frame byte is delivered.
- R9: Outside a packet, bytes without `in_sof` are dropped, even if they carry `in_eof`. They start no frame and add nothing to the next one.
- R10: A byte with `in_sof` that arrives while a packet is being collected drops the bytes collected so far. It starts a new packet and captures a new packet number and link index.
- R11: Payload bytes beyond `MAX_PAYLOAD` are dropped. The length field then reads `MAX_PAYLOAD`.
- R12: After reset, `tx_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input payload byte |
| in_sof | input | 1 | First byte of a packet |
| in_eof | input | 1 | Last byte of a packet |
| in_pkt_id | input | 16 | Packet number, taken with the `in_sof` byte |
| in_link | input | LINK_W | Source link index, taken with the `in_sof` byte |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink takes the output byte |
| tx_data | output | 8 | Output frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |

## Verification
The bench sweeps the payload count from 1 to 50 with a buffer of 48 bytes. The sweep covers short frames that need padding, the count of 38 where padding just stops being needed, longer frames and two overflowing packets. The sink is driven with four `tx_ready` patterns: always ready, alternating, one stall in three and pseudo-random. These separate a correct hold from a lost or doubled byte. Some packets are preceded by stray flagless bytes, and others are interrupted by a restarting `in_sof`. These show whether pre-packet bytes are dropped and whether a restart captures a fresh header. A CRC computed in the bench over the expected bytes catches any byte that enters the check sequence wrongly.

// File: rtl/rdo_encap_pkg.sv
package rdo_encap_pkg;

  localparam int HDR_BYTES = 22;
  localparam int MIN_BODY  = 60;
  localparam int FCS_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EMIT    = 2'd2
  } enc_state_t;

  // One byte of reflected CRC32 (polynomial 0x04C11DB7, reversed 0xEDB88320)
  function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                             input logic [7:0]  b);
    logic [31:0] c;
    c = crc_in ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      if (c[0]) c = (c >> 1) ^ 32'hEDB88320;
      else      c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rdo_payload_buf.sv
module rdo_payload_buf #(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Read is combinational so the output byte tracks the frame position directly
  assign rd_data = (32'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;

endmodule

// File: rtl/rdo_hdr_gen.sv
module rdo_hdr_gen #(
  parameter logic [47:0] DST_MAC    = 48'h02005E102030,
  parameter logic [47:0] SRC_MAC    = 48'h02AABBCCDD01,
  parameter logic [15:0] ETHER_TYPE = 16'h0811,
  parameter logic [15:0] FRAME_TYPE = 16'h0003,
  parameter int          LINK_W     = 4
) (
  input  logic [4:0]        idx,
  input  logic [15:0]       pkt_id,
  input  logic [LINK_W-1:0] link,
  input  logic [15:0]       pay_len,
  output logic [7:0]        hdr_byte
);

  localparam int HB = rdo_encap_pkg::HDR_BYTES;

  logic [HB*8-1:0] hdr_vec;
  logic [7:0]      hdr_tab [32];

  assign hdr_vec = {DST_MAC, SRC_MAC, ETHER_TYPE, FRAME_TYPE,
                    16'(link), pkt_id, pay_len};

  for (genvar g = 0; g < 32; g++) begin : g_tab
    if (g < HB) begin : g_used
      assign hdr_tab[g] = hdr_vec[HB*8-1-8*g -: 8];
    end else begin : g_zero
      assign hdr_tab[g] = 8'h00;
    end
  end

  assign hdr_byte = hdr_tab[idx];

endmodule

// File: rtl/rdo_crc_acc.sv
module rdo_crc_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] fcs
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc_q <= 32'hFFFFFFFF;
    else if (en)         crc_q <= rdo_encap_pkg::crc32_step(crc_q, data);
  end

  assign fcs = ~crc_q;

endmodule

// File: rtl/rdo_frame_encap.sv
module rdo_frame_encap #(
  parameter int          MAX_PAYLOAD = 256,
  parameter int          LINK_W      = 4,
  parameter logic [47:0] DST_MAC     = 48'h02005E102030,
  parameter logic [47:0] SRC_MAC     = 48'h02AABBCCDD01,
  parameter logic [15:0] ETHER_TYPE  = 16'h0811,
  parameter logic [15:0] FRAME_TYPE  = 16'h0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [15:0]       in_pkt_id,
  input  logic [LINK_W-1:0] in_link,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof
);
  import rdo_encap_pkg::*;

  localparam int AW    = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1;
  localparam int LEN_W = $clog2(MAX_PAYLOAD + 1);
  localparam int POS_W = $clog2(HDR_BYTES + MAX_PAYLOAD + MIN_BODY + FCS_BYTES);

  enc_state_t        state_q;
  logic [LEN_W-1:0]  cnt_q, cnt_base, cnt_nxt;
  logic [LEN_W-1:0]  len_q;
  logic [15:0]       pkt_id_q;
  logic [LINK_W-1:0] link_q;
  logic [POS_W-1:0]  pos_q;

  logic              accept, take_byte, room;
  logic              wr_en;
  logic [7:0]        pay_byte, hdr_byte;
  logic [31:0]       fcs;
  logic [POS_W-1:0]  pay_end, body_end, last_pos;
  logic              in_hdr, in_pay, in_body;
  logic [1:0]        fcs_sel;
  logic [7:0]        fcs_byte;

  // ---------------- input side ----------------
  assign in_ready  = (state_q != ST_EMIT);
  assign accept    = in_valid && in_ready;
  assign take_byte = accept && (in_sof || state_q == ST_COLLECT);
  assign cnt_base  = in_sof ? '0 : cnt_q;
  assign room      = (32'(cnt_base) < MAX_PAYLOAD);
  assign cnt_nxt   = room ? cnt_base + LEN_W'(1) : cnt_base;
  assign wr_en     = take_byte && room;

  rdo_payload_buf #(.DEPTH(MAX_PAYLOAD)) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (AW'(cnt_base)),
    .wr_data (in_data),
    .rd_addr (AW'(pos_q - POS_W'(HDR_BYTES))),
    .rd_data (pay_byte)
  );

  // ---------------- frame layout ----------------
  assign pay_end  = POS_W'(HDR_BYTES) + POS_W'(len_q);
  assign body_end = (pay_end > POS_W'(MIN_BODY)) ? pay_end : POS_W'(MIN_BODY);
  assign last_pos = body_end + POS_W'(FCS_BYTES - 1);
  assign in_hdr   = (pos_q < POS_W'(HDR_BYTES));
  assign in_pay   = (pos_q < pay_end);
  assign in_body  = (pos_q < body_end);
  assign fcs_sel  = 2'(pos_q - body_end);

  rdo_hdr_gen #(
    .DST_MAC    (DST_MAC),
    .SRC_MAC    (SRC_MAC),
    .ETHER_TYPE (ETHER_TYPE),
    .FRAME_TYPE (FRAME_TYPE),
    .LINK_W     (LINK_W)
  ) u_hdr (
    .idx      (5'(pos_q)),
    .pkt_id   (pkt_id_q),
    .link     (link_q),
    .pay_len  (16'(len_q)),
    .hdr_byte (hdr_byte)
  );

  rdo_crc_acc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state_q != ST_EMIT),
    .en    (tx_valid && tx_ready && in_body),
    .data  (tx_data),
    .fcs   (fcs)
  );

  always_comb begin
    case (fcs_sel)
      2'd0:    fcs_byte = fcs[7:0];
      2'd1:    fcs_byte = fcs[15:8];
      2'd2:    fcs_byte = fcs[23:16];
      default: fcs_byte = fcs[31:24];
    endcase
  end

  // ---------------- output side ----------------
  always_comb begin
    if (in_hdr)       tx_data = hdr_byte;
    else if (in_pay)  tx_data = pay_byte;
    else if (in_body) tx_data = 8'h00;
    else              tx_data = fcs_byte;
  end

  assign tx_valid = (state_q == ST_EMIT);
  assign tx_sof   = tx_valid && (pos_q == '0);
  assign tx_eof   = tx_valid && (pos_q == last_pos);

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      len_q    <= '0;
      pkt_id_q <= '0;
      link_q   <= '0;
      pos_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_COLLECT: begin
          if (accept && in_sof) begin
            pkt_id_q <= in_pkt_id;
            link_q   <= in_link;
          end
          if (take_byte) begin
            cnt_q <= cnt_nxt;
            if (in_eof) begin
              state_q <= ST_EMIT;
              len_q   <= cnt_nxt;
              pos_q   <= '0;
            end else begin
              state_q <= ST_COLLECT;
            end
          end
        end
        ST_EMIT: begin
          if (tx_ready) begin
            if (pos_q == last_pos) begin
              state_q <= ST_IDLE;
              pos_q   <= '0;
              cnt_q   <= '0;
            end else begin
              pos_q <= pos_q + POS_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rdo_frame_encap_chk.sv
module rdo_frame_encap_chk #(
  parameter logic [47:0] DST_MAC = 48'h02005E102030
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_sof,
  input logic       tx_eof
);

  logic [15:0] frame_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) frame_cnt <= '0;
    else if (tx_valid && tx_ready) frame_cnt <= tx_eof ? 16'd0 : frame_cnt + 16'd1;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

  assert_mutex_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && in_ready));

  assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eof |=> in_ready && !tx_valid);

  assert_dst_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sof |-> tx_data == DST_MAC[47:40]);

  assert_min_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_eof |-> frame_cnt >= 16'd63);

  assert_sof_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_sof == (frame_cnt == 16'd0)));

endmodule

bind rdo_frame_encap rdo_frame_encap_chk #(.DST_MAC(DST_MAC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_sof   (tx_sof),
  .tx_eof   (tx_eof)
);

// File: tb/rdo_frame_encap_bench.sv
module rdo_frame_encap_bench;

  localparam int          MAXP  = 48;
  localparam int          LW    = 2;
  localparam logic [47:0] DST   = 48'h02005E102030;
  localparam logic [47:0] SRC   = 48'h02AABBCCDD01;
  localparam logic [15:0] ETYP  = 16'h0811;
  localparam logic [15:0] FTYP  = 16'h0003;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]    in_data = '0;
  logic [15:0]   in_pkt_id = '0;
  logic [LW-1:0] in_link = '0;
  logic          in_ready;
  logic          tx_valid, tx_sof, tx_eof;
  logic          tx_ready = 1'b1;
  logic [7:0]    tx_data;

  int checks = 0, errors = 0;
  int stall_bad = 0, mutex_bad = 0;

  logic [7:0] gbuf [128];
  logic       gsof [128];
  logic       geof [128];
  int         got_n;
  logic [7:0] exp_b [128];

  always #2 clk = ~clk;

  rdo_frame_encap #(
    .MAX_PAYLOAD(MAXP), .LINK_W(LW), .DST_MAC(DST), .SRC_MAC(SRC),
    .ETHER_TYPE(ETYP), .FRAME_TYPE(FTYP)
  ) u_rdo_frame_encap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_pkt_id(in_pkt_id), .in_link(in_link), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, expv, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] pbyte(input int seed, input int i);
    return 8'((seed * 7 + i * 13) ^ 8'h5A);
  endfunction

  task automatic push_byte(input logic [7:0] b, input bit s, input bit e,
                           input logic [15:0] id, input logic [LW-1:0] lk);
    in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e; in_pkt_id = id; in_link = lk;
    while (1) begin
      bit r;
      r = in_ready;
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic drive(input int n, input int mode, input bit stray, input bit restart);
    if (stray) begin
      for (int i = 0; i < 3; i++) push_byte(8'hC0 + 8'(i), 1'b0, i == 2, 16'hBEEF, LW'(3));
    end
    if (restart) begin
      for (int i = 0; i < 5; i++) push_byte(8'hE0 + 8'(i), i == 0, 1'b0, 16'hDEAD, LW'(3));
    end
    for (int i = 0; i < n; i++) begin
      push_byte(pbyte(n, i), i == 0, i == n - 1, 16'(n * 257), LW'(n % 4));
      if (mode == 2 && (i % 2) == 1) @(negedge clk);
    end
  endtask

  task automatic collect(input int mode);
    logic [7:0] lf = 8'hA5;
    bit pv = 0, pr = 0;
    logic [7:0] pd = '0;
    int cyc = 0;
    bit done = 0;
    got_n = 0;
    while (!done) begin
      bit r;
      @(negedge clk);
      if (pv && !pr && (!tx_valid || tx_data != pd)) stall_bad++;
      if (tx_valid && in_ready) mutex_bad++;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      case (mode)
        0: r = 1'b1;
        1: r = cyc[0];
        2: r = (cyc % 3) != 0;
        default: r = lf[0] | lf[2];
      endcase
      cyc++;
      tx_ready = r;
      pv = tx_valid; pr = r; pd = tx_data;
      if (tx_valid && r && got_n < 128) begin
        gbuf[got_n] = tx_data; gsof[got_n] = tx_sof; geof[got_n] = tx_eof;
        got_n++;
        if (tx_eof) done = 1;
      end
    end
  endtask

  task automatic verify(input int n, input string ptag);
    int elen, body, total, bad;
    logic [31:0] c;
    elen  = (n > MAXP) ? MAXP : n;
    body  = (22 + elen > 60) ? 22 + elen : 60;
    total = body + 4;
    for (int i = 0; i < 128; i++) exp_b[i] = 8'h00;
    for (int i = 0; i < 6; i++) begin
      exp_b[i]     = DST[47 - 8*i -: 8];
      exp_b[6 + i] = SRC[47 - 8*i -: 8];
    end
    exp_b[12] = ETYP[15:8];  exp_b[13] = ETYP[7:0];
    exp_b[14] = FTYP[15:8];  exp_b[15] = FTYP[7:0];
    exp_b[16] = 8'h00;       exp_b[17] = 8'(n % 4);
    exp_b[18] = 8'((n * 257) >> 8); exp_b[19] = 8'(n * 257);
    exp_b[20] = 8'(elen >> 8);      exp_b[21] = 8'(elen);
    for (int i = 0; i < elen; i++) exp_b[22 + i] = pbyte(n, i);
    c = 32'hFFFFFFFF;
    for (int i = 0; i < body; i++) c = ref_crc(c, exp_b[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) exp_b[body + i] = c[8*i +: 8];

    check(got_n == total, "R4 frame length", got_n, total);
    bad = -1;
    for (int i = 0; i < 14; i++) if (bad < 0 && gbuf[i] != exp_b[i]) bad = i;
    check(bad < 0, "R1 address/type byte", (bad < 0) ? 0 : int'(gbuf[bad]), (bad < 0) ? 0 : int'(exp_b[bad]));
    bad = -1;
    for (int i = 14; i < 22; i++) if (bad < 0 && gbuf[i] != exp_b[i]) bad = i;
    check(bad < 0, "R2 header byte", (bad < 0) ? 0 : int'(gbuf[bad]), (bad < 0) ? 0 : int'(exp_b[bad]));
    bad = -1;
    for (int i = 22; i < 22 + elen; i++) if (bad < 0 && gbuf[i] != exp_b[i]) bad = i;
    check(bad < 0, {ptag, " payload byte"}, (bad < 0) ? 0 : int'(gbuf[bad]), (bad < 0) ? 0 : int'(exp_b[bad]));
    bad = -1;
    for (int i = 22 + elen; i < body && i < got_n; i++) if (bad < 0 && gbuf[i] != 8'h00) bad = i;
    check(bad < 0, "R4 pad byte", (bad < 0) ? 0 : int'(gbuf[bad]), 0);
    bad = -1;
    for (int i = body; i < total && i < got_n; i++) if (bad < 0 && gbuf[i] != exp_b[i]) bad = i;
    check(bad < 0, "R5 fcs byte", (bad < 0) ? 0 : int'(gbuf[bad]), (bad < 0) ? 0 : int'(exp_b[bad]));
    bad = -1;
    for (int i = 0; i < got_n; i++)
      if (bad < 0 && (gsof[i] != (i == 0) || geof[i] != (i == got_n - 1))) bad = i;
    check(bad < 0, "R6 flag position", bad, -1);
    if (n > MAXP) check({gbuf[20], gbuf[21]} == 16'(MAXP), "R11 length field",
                        int'({gbuf[20], gbuf[21]}), MAXP);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_valid == 1'b0, "R12 tx_valid after reset", int'(tx_valid), 0);
    check(in_ready == 1'b1, "R12 in_ready after reset", int'(in_ready), 1);
    for (int n = 1; n <= 50; n++) begin
      int mode;
      bit stray, restart;
      string tag;
      mode    = n % 4;
      stray   = (n % 5) == 0;
      restart = (n % 7) == 0;
      tag = (n > MAXP) ? "R11" : restart ? "R10" : stray ? "R9" : "R3";
      fork
        drive(n, mode, stray, restart);
        collect(mode);
      join
      tx_ready = 1'b1;
      verify(n, tag);
    end
    check(stall_bad == 0, "R7 output changed while stalled", stall_bad, 0);
    check(mutex_bad == 0, "R8 in_ready high during frame", mutex_bad, 0);
    @(negedge clk);
    check(in_ready == 1'b1 && tx_valid == 1'b0, "R8 idle after last frame",
          int'({in_ready, tx_valid}), 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule